// File: doc/BRIEF.md
# Configurable Exclusive-OR Output Macrocell

One output cell of a small programmable logic device. Four product terms arrive from the AND array. Two mode bits and a polarity bit choose how the cell turns them into a pin value. In the two plain modes, three terms are ORed and the fourth term drives the pin's tri-state enable. In the two exclusive-OR modes, the terms form two ORed pairs that are exclusive-ORed, and a shared active-low enable pin controls the output. Each pair of modes has a registered variant and a combinatorial variant. The registered variants use a D flip-flop clocked on the rising edge of the shared clock.

The cell returns a feedback bit to the array. In the registered modes this bit is the flip-flop state. In the combinatorial modes it is the pin state: the driven value while the output is enabled, and the externally applied pin value while it is not. The pad itself is modelled as a data output plus an enable output. The output stage inverts. A power-up reset clears the flip-flop, so an enabled registered pin comes up high whatever polarity is programmed.

Top module: `xor_macrocell`

## Requirements
- R1: The mode is the field {mode_sum, mode_comb}. 1,0 selects plain registered, 1,1 plain combinatorial, 0,1 XOR combinatorial and 0,0 XOR registered.
- R2: In the plain modes (mode_sum=1), pin_en equals pt[3], and oe_n has no effect on it.
- R3: In the XOR modes (mode_sum=0), pin_en equals the inverse of oe_n, and pt[3] has no effect on it.
- R4: In plain combinatorial mode, pin_data equals pt[0]|pt[1]|pt[2] when pol_low=0 and the inverse of that sum when pol_low=1.
- R5: In XOR combinatorial mode, pin_data equals the inverse of (pt[0]|pt[1]) ^ (pt[2]|pt[3]), and pol_low has no effect.
- R6: In plain registered mode, after a rising clock edge pin_data shows the value pt[0]|pt[1]|pt[2] had at that edge. It shows the sum itself when pol_low was 0 at that edge and the inverse when pol_low was 1. Between edges, pin_data does not change.
- R7: In XOR registered mode, after a rising clock edge pin_data equals the inverse of (pt[0]|pt[1]) ^ (pt[2]|pt[3]) as sampled at that edge.
- R8: In both registered modes, fb is the flip-flop state, which is always the inverse of pin_data. It does not depend on pin_in or pin_en.
- R9: In both combinatorial modes, fb equals pin_data while pin_en=1 and equals pin_in while pin_en=0.
- R10: A rising edge with rst=1 clears the flip-flop. In a registered mode this makes fb=0 and pin_data=1 for either polarity.
- R11: While rst=1, clock edges do not load the flip-flop, whatever the product terms are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared register clock, rising edge |
| rst | input | 1 | Power-up reset, active high, sampled on clk |
| pt | input | 4 | Product terms from the AND array |
| oe_n | input | 1 | Shared active-low output enable for XOR modes |
| mode_sum | input | 1 | 1: single three-term sum; 0: paired sums exclusive-ORed |
| mode_comb | input | 1 | 1: combinatorial; 0: registered |
| pol_low | input | 1 | Output polarity in plain modes: 1 active low |
| pin_in | input | 1 | Value applied to the pin from outside while the output is off |
| pin_data | output | 1 | Value driven toward the pad |
| pin_en | output | 1 | Tri-state enable of the pad |
| fb | output | 1 | Feedback bit to the AND array |

## Verification
The flip-flop is the only state in the cell, and it is visible on pin_data in the registered modes the moment it changes. A wrong load, a lost reset or a missing edge therefore shows on pin_data within one clock. It also shows as an inverted fb in the same cycle, because the two ports must always be complements in these modes. The bench models the registered value itself from the sampled product terms and polarity, and compares pin_data and fb after every edge. Reset is applied with both polarities to expose any polarity dependence of the power-up value.

// File: rtl/xor_macrocell.sv
module xor_macrocell (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] pt,
  input  logic       oe_n,
  input  logic       mode_sum,
  input  logic       mode_comb,
  input  logic       pol_low,
  input  logic       pin_in,
  output logic       pin_data,
  output logic       pin_en,
  output logic       fb
);

  logic sum3;
  logic pair_x;
  logic d_in;
  logic q;
  logic comb_val;

  assign sum3   = pt[0] | pt[1] | pt[2];
  assign pair_x = (pt[0] | pt[1]) ^ (pt[2] | pt[3]);

  // pre-inverted so the inverting output stage yields the wanted polarity
  assign d_in = mode_sum ? (pol_low ? sum3 : ~sum3) : pair_x;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d_in;
  end

  assign comb_val = mode_sum ? (pol_low ? ~sum3 : sum3) : ~pair_x;

  assign pin_en   = mode_sum ? pt[3] : ~oe_n;
  assign pin_data = mode_comb ? comb_val : ~q;
  assign fb       = mode_comb ? (pin_en ? pin_data : pin_in) : q;

endmodule

module xor_macrocell_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] pt,
  input logic       oe_n,
  input logic       mode_sum,
  input logic       mode_comb,
  input logic       pol_low,
  input logic       pin_in,
  input logic       pin_data,
  input logic       pin_en,
  input logic       fb
);

  // R2
  plain_en_chk: assert property (@(posedge clk) disable iff (rst)
    mode_sum |-> pin_en == pt[3]);

  // R3
  xor_en_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_sum |-> pin_en == !oe_n);

  // R4
  plain_comb_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sum && mode_comb) |->
      pin_data == (pol_low ^ (pt[0] | pt[1] | pt[2])));

  // R5
  xor_comb_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_sum && mode_comb) |->
      pin_data == !((pt[0] | pt[1]) ^ (pt[2] | pt[3])));

  // R6
  plain_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sum && !mode_comb && $stable({mode_sum, mode_comb}) && !$past(rst)) |->
      pin_data == ($past(pol_low) ^ $past(pt[0] | pt[1] | pt[2])));

  // R7
  xor_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_sum && !mode_comb && $stable({mode_sum, mode_comb}) && !$past(rst)) |->
      pin_data == !$past((pt[0] | pt[1]) ^ (pt[2] | pt[3])));

  // R8
  reg_fb_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_comb |-> fb == !pin_data);

  // R9
  comb_fb_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_comb && !pin_en) |-> fb == pin_in);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    ($past(rst) && !mode_comb) |-> (fb == 1'b0 && pin_data == 1'b1));

endmodule

bind xor_macrocell xor_macrocell_chk chk_i (
  .clk(clk), .rst(rst), .pt(pt), .oe_n(oe_n), .mode_sum(mode_sum),
  .mode_comb(mode_comb), .pol_low(pol_low), .pin_in(pin_in),
  .pin_data(pin_data), .pin_en(pin_en), .fb(fb)
);

// File: tb/xor_macrocell_test.sv
module xor_macrocell_test;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] pt;
  logic       oe_n, mode_sum, mode_comb, pol_low, pin_in;
  logic       pin_data, pin_en, fb;

  always #5 clk = ~clk;

  xor_macrocell uut (
    .clk(clk), .rst(rst), .pt(pt), .oe_n(oe_n), .mode_sum(mode_sum),
    .mode_comb(mode_comb), .pol_low(pol_low), .pin_in(pin_in),
    .pin_data(pin_data), .pin_en(pin_en), .fb(fb)
  );

  typedef struct {
    logic  data;
    logic  en;
    logic  fbk;
    string tag;
  } exp_t;

  exp_t  sb[$];
  event  chk_ev;
  int    n_chk = 0;
  int    n_fail = 0;
  logic  mq = 1'b0;
  bit    done = 1'b0;

  initial begin
    forever begin
      @(chk_ev);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (pin_data !== e.data || pin_en !== e.en || fb !== e.fbk) begin
          n_fail++;
          $display("FAIL %s: data/en/fb got %b%b%b expected %b%b%b",
                   e.tag, pin_data, pin_en, fb, e.data, e.en, e.fbk);
        end
      end
    end
  end

  task automatic step(input logic [3:0] p, input logic s, input logic c,
                      input logic pl, input logic oen, input logic pi,
                      input logic r, input bit clock, input string tag);
    logic o3, xs, en, dat, fbk;
    exp_t e;
    @(negedge clk);
    pt = p; mode_sum = s; mode_comb = c; pol_low = pl;
    oe_n = oen; pin_in = pi; rst = r;
    o3 = p[0] | p[1] | p[2];
    xs = (p[0] | p[1]) ^ (p[2] | p[3]);
    if (clock) begin
      @(posedge clk);
      if (r) mq = 1'b0;
      else if (s) mq = pl ? o3 : ~o3;
      else mq = xs;
    end
    #2;
    en = s ? p[3] : ~oen;
    if (!c) begin
      dat = ~mq;
      fbk = mq;
    end else begin
      dat = s ? (pl ? ~o3 : o3) : ~xs;
      fbk = en ? dat : pi;
    end
    e.data = dat; e.en = en; e.fbk = fbk; e.tag = tag;
    sb.push_back(e);
    ->chk_ev;
    #1;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pt = 4'h0; oe_n = 1'b0; mode_sum = 1'b1; mode_comb = 1'b0;
    pol_low = 1'b0; pin_in = 1'b0;

    // R10 R11: reset with both polarities and busy product terms
    step(4'hF, 1, 0, 0, 0, 0, 1, 1, "R10 reset pol0");
    step(4'hF, 1, 0, 1, 0, 1, 1, 1, "R10 reset pol1");
    step(4'h9, 0, 0, 0, 0, 0, 1, 1, "R11 reset xor reg");
    step(4'hE, 1, 0, 0, 0, 0, 1, 1, "R11 edge ignored in reset");

    // R1 R4 R2: plain combinatorial
    step(4'h0, 1, 1, 0, 0, 0, 0, 0, "R4 sum0 pol0");
    step(4'h2, 1, 1, 0, 1, 0, 0, 0, "R4 sum1 pol0");
    step(4'hC, 1, 1, 1, 0, 0, 0, 0, "R4 sum1 pol1 R2 en");
    step(4'h8, 1, 1, 1, 0, 0, 0, 0, "R4 pt3 only pol1");
    step(4'h8, 1, 1, 0, 1, 1, 0, 0, "R2 oe_n ignored");
    // R9: disabled pin reads pin_in
    step(4'h1, 1, 1, 0, 0, 1, 0, 0, "R9 off pin_in1");
    step(4'h1, 1, 1, 0, 0, 0, 0, 0, "R9 off pin_in0");

    // R1 R5 R3: XOR combinatorial
    step(4'h0, 0, 1, 0, 0, 1, 0, 0, "R5 00");
    step(4'h2, 0, 1, 0, 0, 1, 0, 0, "R5 10");
    step(4'h4, 0, 1, 1, 0, 0, 0, 0, "R5 01 pol ignored");
    step(4'hB, 0, 1, 0, 0, 0, 0, 0, "R5 11");
    step(4'h8, 0, 1, 0, 1, 1, 0, 0, "R3 off pt3 ignored R9");
    step(4'h7, 0, 1, 0, 1, 0, 0, 0, "R3 off R9 pin_in0");

    // R1 R6 R8: plain registered
    step(4'h1, 1, 0, 0, 0, 1, 0, 1, "R6 sum1 pol0");
    step(4'h8, 1, 0, 0, 0, 1, 0, 1, "R6 sum0 pol0 R8");
    step(4'h4, 1, 0, 1, 0, 0, 0, 1, "R6 sum1 pol1");
    step(4'h0, 1, 0, 1, 0, 1, 0, 1, "R6 sum0 pol1 R2 off R8");
    step(4'h7, 1, 0, 0, 0, 0, 0, 0, "R6 holds between edges");

    // R1 R7 R8: XOR registered
    step(4'h3, 0, 0, 0, 0, 0, 0, 1, "R7 10");
    step(4'hC, 0, 0, 0, 0, 1, 0, 1, "R7 01 R8");
    step(4'hF, 0, 0, 1, 1, 1, 0, 1, "R7 11 R3 off R8");
    step(4'h6, 0, 0, 0, 0, 0, 0, 1, "R7 11 again");
    step(4'h1, 0, 0, 0, 0, 0, 0, 1, "R7 load 1");

    // R10 R11: reset again after a loaded value
    step(4'hF, 0, 0, 0, 0, 0, 1, 1, "R10 reset clears xor reg");
    step(4'h1, 1, 0, 1, 0, 0, 1, 1, "R11 no load in reset pol1");
    step(4'h2, 1, 0, 1, 0, 0, 0, 1, "R6 resume after reset");

    #20;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule